// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Up-Counting Timer

This block is a 16-bit up-counter that a processor with an 8-bit data bus programs and samples one byte at a time. The count advances once per tick from a selectable power-of-two prescaler. When the count wraps from 0xFFFF to 0x0000, a sticky interrupt flag is set. Only software clears the flag. The counter is never reloaded by hardware. After every wrap, software writes a new start value, computed as 65536 minus (interval × tick rate).

Shadow registers make both directions of a 16-bit access atomic. A write to the high-byte address only stages the byte in a holding register. The following write to the low-byte address loads the staged byte and the new low byte into the counter together. A read of the low-byte address returns the live low byte and, at the same edge, captures the live high byte into a snapshot. A later read of the high-byte address returns that snapshot rather than the running value.

A control byte holds the enable bit, the prescaler select and the readback of the flag. The flag also drives the interrupt request output.

Top module: `byte_timer16`

## Requirements
- R1: After reset the count, the high-byte holding register, the snapshot, the enable bit, the prescaler select and the flag are all zero, so reads of 0xA0, 0xA1 and 0xA2 return 0x00 and `irq_o` is low.
- R2: A write to 0xA2 only stores the byte in the holding register and leaves the count unchanged.
- R3: A write to 0xA1 loads {holding byte, written byte} into the count at the next clock edge. If a tick falls in the same cycle, the load wins and the tick is lost.
- R4: A read of 0xA1 returns the live count bits [7:0] in the same cycle and captures the live bits [15:8] into the snapshot at the clock edge. A read of 0xA2 returns the snapshot.
- R5: While enabled, the count rises by one on each tick. While disabled, it holds its value, the prescaler is held at zero, and the access rules of R2 to R4 still apply.
- R6: The prescaler select code s (0 to 7) divides the clock by 2^(7-s), so code 0 gives divide by 128, code 6 gives divide by 2 and code 7 gives divide by 1. The first increment lands 2^(7-s) edges after the edge that sets the enable bit.
- R7: When a tick arrives at count 0xFFFF with no load, the count becomes 0x0000 and the flag is set. Counting then continues from 0x0000 with no reload.
- R8: A control write with bit 7 = 0 clears the flag, and bit 7 = 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set. `irq_o` follows the flag.
- R9: The control byte at 0xA0 has the select code in bits [2:0] and the enable bit in bit 3, both written by control writes. It reads back as {flag, 3'b000, enable, select}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Byte write strobe |
| bus_re_i | input | 1 | Byte read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational, zero when no read |
| irq_o | output | 1 | Sticky interrupt request (flag) |

## Verification
Read data is combinational, so the bench samples it 1 ns after driving the read, in the same cycle. The snapshot, holding register, control byte and flag change at the edge that ends a write or read cycle, so their effects are checked from the following negative edge onward. A count increment caused by a tick in cycle k appears after edge k+1. Each timing scenario therefore counts negative edges from the edge that sets the enable bit and samples at computed points: for example, the flag is checked as still low at the 256th edge and high at the 257th under divide by 128. The collision cases place a write and a tick in the same cycle on purpose: a load against a tick, and a clearing write against a wrap.

// File: rtl/byte_timer16_pkg.sv
package byte_timer16_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CNT_W    = 2 * BYTE_W;
  localparam int unsigned DIV_LOG2 = 7;
  localparam int unsigned SEL_W    = $clog2(DIV_LOG2 + 1);
endpackage

// File: rtl/byte_timer16_psc.sv
module byte_timer16_psc
  import byte_timer16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_LOG2-1:0] div_q, mask;

  // select s keeps the low (DIV_LOG2 - s) bits in the terminal-count mask
  always_comb begin
    for (int i = 0; i < DIV_LOG2; i++)
      mask[i] = (i < (int'(DIV_LOG2) - int'(sel_i)));
  end

  assign tick_o = en_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (!en_i) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // R6
  full_rate_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sel_i == SEL_W'(DIV_LOG2)) |-> tick_o);
  // R5
  idle_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (div_q == '0));
endmodule

// File: rtl/byte_timer16_core.sv
module byte_timer16_core
  import byte_timer16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, wrap;

  assign wrap = tick_i && !load_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // a wrap beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (wrap)  flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R7
  wrap_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '1) |=> (flag_o && cnt_o == '0));
  // R3
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o == $past(load_val_i)));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/byte_timer16_regs.sv
module byte_timer16_regs
  import byte_timer16_pkg::*;
#(
  parameter int unsigned      ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 'hA0,
  parameter logic [ADDR_W-1:0] ADDR_LO   = 'hA1,
  parameter logic [ADDR_W-1:0] ADDR_HI   = 'hA2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_o,
  output logic              en_o,
  output logic [SEL_W-1:0]  sel_o
);
  localparam int unsigned EN_BIT   = SEL_W;
  localparam int unsigned FLAG_BIT = BYTE_W - 1;

  logic [BYTE_W-1:0] hold_q, snap_q, ctrl_rd;
  logic [SEL_W-1:0]  sel_q;
  logic              en_q;
  logic              wr_lo, wr_hi, wr_ctrl, rd_lo;

  assign wr_lo   = we_i && (addr_i == ADDR_LO);
  assign wr_hi   = we_i && (addr_i == ADDR_HI);
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign rd_lo   = re_i && (addr_i == ADDR_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      snap_q <= '0;
      en_q   <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (wr_hi) hold_q <= wdata_i;
      if (rd_lo) snap_q <= cnt_i[CNT_W-1:BYTE_W];
      if (wr_ctrl) begin
        en_q  <= wdata_i[EN_BIT];
        sel_q <= wdata_i[SEL_W-1:0];
      end
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[SEL_W-1:0] = sel_q;
    ctrl_rd[EN_BIT]   = en_q;
    ctrl_rd[FLAG_BIT] = flag_i;
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (addr_i == ADDR_LO)        rdata_o = cnt_i[BYTE_W-1:0];
      else if (addr_i == ADDR_HI)   rdata_o = snap_q;
      else if (addr_i == ADDR_CTRL) rdata_o = ctrl_rd;
    end
  end

  assign load_o     = wr_lo;
  assign load_val_o = {hold_q, wdata_i};
  assign clr_o      = wr_ctrl && !wdata_i[FLAG_BIT];
  assign en_o       = en_q;
  assign sel_o      = sel_q;

  // R4
  snap_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo |=> (snap_q == $past(cnt_i[CNT_W-1:BYTE_W])));
  // R2
  stage_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hi) |=> $stable(hold_q));
endmodule

// File: rtl/byte_timer16.sv
module byte_timer16
  import byte_timer16_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt, load_val;
  logic [SEL_W-1:0] sel;
  logic             load, clr, en, tick, flag;

  byte_timer16_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(bus_we_i), .re_i(bus_re_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .cnt_i(cnt), .flag_i(flag), .rdata_o(bus_rdata_o),
    .load_o(load), .load_val_o(load_val), .clr_o(clr), .en_o(en), .sel_o(sel)
  );

  byte_timer16_psc u_psc (
    .clk_i, .rst_ni, .en_i(en), .sel_i(sel), .tick_o(tick)
  );

  byte_timer16_core u_core (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .load_val_i(load_val),
    .clr_i(clr), .cnt_o(cnt), .flag_o(flag)
  );

  assign irq_o = flag;

  // R8
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !tick) |=> !irq_o);
endmodule

// File: tb/byte_timer16_tb_top.sv
`timescale 1ns/1ps
module byte_timer16_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] A_CTRL = 8'hA0, A_LO = 8'hA1, A_HI = 8'hA2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_timer16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start just after a negedge and return at the next one
  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic commit16(input logic [15:0] v);
    bus_wr(A_HI, v[15:8]);
    bus_wr(A_LO, v[7:0]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq", {7'b0, irq}, 8'h00);
    bus_rd(A_LO, d);   check("R1 lo", d, 8'h00);
    bus_rd(A_HI, d);   check("R1 hi", d, 8'h00);
    bus_rd(A_CTRL, d); check("R1 ctrl", d, 8'h00);
  endtask

  task automatic t_stage;
    logic [7:0] d;
    commit16(16'h1234);
    bus_wr(A_HI, 8'h55);
    bus_rd(A_LO, d); check("R2 lo after hi-only", d, 8'h34);
    bus_rd(A_HI, d); check("R2 hi after hi-only", d, 8'h12);
  endtask

  task automatic t_snapshot;
    logic [7:0] d;
    bus_rd(A_LO, d);
    commit16(16'h9A78);
    bus_rd(A_HI, d); check("R4 stale snapshot", d, 8'h12);
    bus_rd(A_LO, d); check("R3 new lo", d, 8'h78);
    bus_rd(A_HI, d); check("R4 new snapshot", d, 8'h9A);
  endtask

  task automatic t_div1_hold;
    logic [7:0] d;
    commit16(16'h0005);
    bus_wr(A_CTRL, 8'h8F);
    repeat (10) @(negedge clk);
    bus_wr(A_CTRL, 8'h87);       // 11 increments in total
    bus_rd(A_LO, d); check("R5 div1 lo", d, 8'h10);
    bus_rd(A_HI, d); check("R5 div1 hi", d, 8'h00);
    repeat (20) @(negedge clk);
    bus_rd(A_LO, d); check("R5 disabled hold", d, 8'h10);
    bus_rd(A_CTRL, d); check("R9 ctrl readback", d, 8'h07);
  endtask

  task automatic t_div2;
    logic [7:0] d;
    commit16(16'h0000);
    bus_wr(A_CTRL, 8'h8E);
    repeat (9) @(negedge clk);
    bus_wr(A_CTRL, 8'h86);
    bus_rd(A_LO, d); check("R6 div2 count", d, 8'h05);
  endtask

  task automatic t_div128_wrap;
    logic [7:0] d;
    commit16(16'hFFFE);
    bus_wr(A_CTRL, 8'h88);
    repeat (255) @(negedge clk);
    check("R6 irq before 256th edge", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R7 irq after wrap", {7'b0, irq}, 8'h01);
    bus_rd(A_LO, d);   check("R7 wrapped lo", d, 8'h00);
    bus_rd(A_HI, d);   check("R7 no reload hi", d, 8'h00);
    bus_rd(A_CTRL, d); check("R9 ctrl with flag", d, 8'h88);
    bus_wr(A_CTRL, 8'h80);
    check("R8 flag sticky", {7'b0, irq}, 8'h01);
    bus_wr(A_CTRL, 8'h00);
    check("R8 flag cleared", {7'b0, irq}, 8'h00);
    bus_wr(A_CTRL, 8'h80);
    check("R8 bit7 set no effect", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_clear_collision;
    logic [7:0] d;
    commit16(16'hFFFF);
    bus_wr(A_CTRL, 8'h8F);
    bus_wr(A_CTRL, 8'h07);       // clear lands on the wrapping edge
    check("R8 wrap beats clear", {7'b0, irq}, 8'h01);
    bus_rd(A_LO, d); check("R7 collision wrap lo", d, 8'h00);
    bus_wr(A_CTRL, 8'h07);
    check("R8 later clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_load_wins;
    logic [7:0] d;
    commit16(16'h0000);
    bus_wr(A_CTRL, 8'h8F);
    bus_wr(A_HI, 8'h40);
    bus_wr(A_LO, 8'h20);         // tick in the same cycle
    bus_rd(A_LO, d); check("R3 load beats tick lo", d, 8'h20);
    bus_rd(A_HI, d); check("R3 load beats tick hi", d, 8'h40);
    bus_wr(A_CTRL, 8'h07);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage();
    t_snapshot();
    t_div1_hold();
    t_div2();
    t_div128_wrap();
    t_clear_collision();
    t_load_wins();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule